// File: doc/BRIEF.md
# Single-Bit Serial Pixel Capture

The block receives image data from a camera that delivers its pixels one bit at a time. Four inputs are used: a frame strobe, a line-valid level, a pixel clock and a single data line. The block brings all four into the system clock domain. It takes one data bit on each rising pixel-clock edge that falls inside a valid line, and packs every eight bits into a byte, first bit in the most significant position. Each finished byte goes out on a simple write port to an external frame buffer: address, data and a one-cycle write enable.

A falling edge on the frame strobe arms the block for a new frame. It drops any half-built byte and resets the write address to zero. The frame has a fixed byte count. After the last byte the block pulses a done flag and stops writing. Bytes that arrive after that point are dropped and raise a sticky overflow flag. The flag clears at the next frame strobe fall. After reset the block writes nothing until it has seen the first frame strobe fall.

Top module: `bitser_capture`

## Requirements
- R1: After reset all outputs are low, and no byte is written until the first falling edge of `vsync_i` has been seen.
- R2: One bit of `d0_i` is taken for each low-to-high transition of `pclk_i`. A pixel clock held high for many cycles gives only one bit.
- R3: The first bit taken becomes bit 7 of the byte and the eighth becomes bit 0. A write is issued after every eighth bit.
- R4: Pixel-clock edges while `hsync_i` is low take no bit. Bits already gathered are kept and completed by the next line's bits.
- R5: The first byte after a `vsync_i` falling edge is written at address 0. Each further byte goes to the next address.
- R6: `frame_done_o` is high for exactly one cycle, together with the write of the final byte at address FRAME_BYTES-1.
- R7: After the final byte, further completed bytes are not written and `overflow_o` goes high. It stays high until the next `vsync_i` falling edge.
- R8: A `vsync_i` falling edge discards a partly gathered byte, resets the address to 0 and clears `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Frame strobe; a falling edge starts a frame |
| hsync_i | input | 1 | Line valid, active high |
| pclk_i | input | 1 | Pixel clock from the camera |
| d0_i | input | 1 | Serial pixel data bit |
| wr_en_o | output | 1 | Write strobe to the frame buffer, one cycle per byte |
| wr_addr_o | output | ADDR_W | Byte address within the frame |
| wr_data_o | output | 8 | Assembled byte |
| frame_done_o | output | 1 | One-cycle pulse on the frame's final write |
| overflow_o | output | 1 | Sticky: bytes were dropped after the frame filled |

## Verification
The bench builds the block with FRAME_BYTES set to 6, which gives a 3-bit address. With that size the end of a frame, the done pulse and the overflow drop are reached after a handful of bytes instead of tens of thousands. The default frame size differs only in the compare value and the counter width, and the same logic handles both. The camera side is driven much slower than the system clock, so every pixel-clock edge survives the synchroniser. The tests cover a clock held high for a long time, a byte split across two lines, and a frame restart in the middle of a byte.

// File: rtl/bitser_pkg.sv
package bitser_pkg;
  parameter int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_FULL = 2'd2
  } cap_state_e;
endpackage

// File: rtl/bitser_sync.sv
module bitser_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bitser_edge.sv
module bitser_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/bitser_packer.sv
module bitser_packer #(
  parameter int unsigned WORD_W = bitser_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_nxt;
  logic [CNT_W-1:0]  cnt_q;

  assign shift_nxt = {shift_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else if (restart_i) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
    end else if (sample_i) begin
      shift_q <= shift_nxt;
      if (cnt_q == CNT_LAST) begin
        cnt_q      <= '0;
        word_vld_o <= 1'b1;
        word_o     <= shift_nxt;
      end else begin
        cnt_q      <= cnt_q + 1'b1;
        word_vld_o <= 1'b0;
      end
    end else begin
      word_vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bitser_writer.sv
module bitser_writer #(
  parameter int unsigned FRAME_BYTES = 79056,
  parameter int unsigned ADDR_W      = $clog2(FRAME_BYTES),
  parameter int unsigned WORD_W      = bitser_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              ovf_o
);
  import bitser_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(FRAME_BYTES - 1);

  cap_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CAP_IDLE;
      ptr_q     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      ovf_o     <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      if (restart_i) begin
        state_q <= CAP_RUN;
        ptr_q   <= '0;
        ovf_o   <= 1'b0;
      end else if (word_vld_i) begin
        unique case (state_q)
          CAP_RUN: begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= ptr_q;
            wr_data_o <= word_i;
            if (ptr_q == ADDR_LAST) begin
              state_q <= CAP_FULL;
              done_o  <= 1'b1;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
          CAP_FULL: ovf_o <= 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bitser_capture.sv
module bitser_capture #(
  parameter int unsigned FRAME_BYTES = 79056,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = $clog2(FRAME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              hsync_i,
  input  logic              pclk_i,
  input  logic              d0_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              frame_done_o,
  output logic              overflow_o
);
  localparam int unsigned NUM_IN = 4;

  logic [NUM_IN-1:0] raw_in, sync_in;
  logic [1:0]        edge_in, edge_rise, edge_fall;
  logic              vsync_s, hsync_s, pclk_s, d0_s;
  logic              vsync_fall, bit_take;
  logic              word_vld;
  logic [7:0]        word;

  assign raw_in = {vsync_i, hsync_i, pclk_i, d0_i};
  assign {vsync_s, hsync_s, pclk_s, d0_s} = sync_in;

  bitser_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign edge_in = {vsync_s, pclk_s};

  bitser_edge #(.WIDTH(2)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (edge_in),
    .rise_o(edge_rise),
    .fall_o(edge_fall)
  );

  assign vsync_fall = edge_fall[1];
  assign bit_take   = edge_rise[0] & hsync_s;

  bitser_packer #(.WORD_W(8)) i_packer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (vsync_fall),
    .sample_i  (bit_take),
    .bit_i     (d0_s),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  bitser_writer #(.FRAME_BYTES(FRAME_BYTES), .ADDR_W(ADDR_W), .WORD_W(8)) i_writer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (vsync_fall),
    .word_vld_i(word_vld),
    .word_i    (word),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .done_o    (frame_done_o),
    .ovf_o     (overflow_o)
  );
endmodule

// File: rtl/bitser_capture_chk.sv
module bitser_capture_chk #(
  parameter int unsigned FRAME_BYTES = 79056,
  parameter int unsigned ADDR_W      = $clog2(FRAME_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              frame_done_o,
  input logic              overflow_o,
  input logic              vsync_fall
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(FRAME_BYTES - 1);

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> wr_addr_o <= ADDR_LAST); // R5
  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (wr_en_o && wr_addr_o == ADDR_LAST)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R6
  AST_NO_WR_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !wr_en_o); // R7
  AST_OVF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !vsync_fall) |=> overflow_o); // R7
  AST_VFALL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_fall |=> !overflow_o); // R8
endmodule

bind bitser_capture bitser_capture_chk #(
  .FRAME_BYTES(FRAME_BYTES),
  .ADDR_W     (ADDR_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .frame_done_o(frame_done_o),
  .overflow_o  (overflow_o),
  .vsync_fall  (vsync_fall)
);

// File: tb/test_bitser_capture.sv
`timescale 1ns/1ps
module test_bitser_capture;
  localparam int unsigned FB = 6;
  localparam int unsigned AW = $clog2(FB);

  logic clk = 1'b0, rst_n = 1'b0;
  logic vsync = 1'b0, hsync = 1'b0, pclk = 1'b0, d0 = 1'b0;
  logic          wr_en, done, ovf;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;

  int tests = 0, fails = 0;
  int nlog = 0, done_cnt = 0, done_addr = -1, done_wr = 0;
  logic [7:0] log_d [64];
  int         log_a [64];

  always #2 clk = ~clk;

  bitser_capture #(.FRAME_BYTES(FB)) i_bitser_capture (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .hsync_i(hsync),
    .pclk_i(pclk), .d0_i(d0), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .frame_done_o(done), .overflow_o(ovf)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en && nlog < 64) begin
      log_d[nlog] = wr_data;
      log_a[nlog] = int'(wr_addr);
      nlog++;
    end
    if (rst_n && done) begin
      done_cnt++;
      done_addr = int'(wr_addr);
      done_wr   = int'(wr_en);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int high_len = 4);
    d0 = b;
    wait_n(2);
    pclk = 1'b1;
    wait_n(high_len);
    pclk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    wait_n(6);
  endtask

  task automatic frame_start();
    vsync = 1'b1;
    wait_n(4);
    vsync = 1'b0;
    wait_n(4);
  endtask

  task automatic t_reset();
    check(!wr_en && !done && !ovf && wr_data == 8'h00, "R1 reset outputs", {wr_en, done, ovf}, 0);
    hsync = 1'b1;
    wait_n(3);
    send_byte(8'hC3);
    check(nlog == 0, "R1 no write before first vsync fall", nlog, 0);
    check(!ovf, "R1 no overflow while idle", ovf, 0);
  endtask

  task automatic t_pack();
    frame_start();
    send_byte(8'hA5);
    send_byte(8'h3C);
    check(nlog == 2, "R3 two bytes written", nlog, 2);
    check(log_d[0] == 8'hA5, "R3 MSB first byte0", log_d[0], 8'hA5);
    check(log_d[1] == 8'h3C, "R3 MSB first byte1", log_d[1], 8'h3C);
    check(log_a[0] == 0, "R5 first address", log_a[0], 0);
    check(log_a[1] == 1, "R5 next address", log_a[1], 1);
  endtask

  task automatic t_line_split();
    int base = nlog;
    send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    wait_n(2);
    hsync = 1'b0;
    wait_n(3);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    wait_n(4);
    check(nlog == base, "R4 no bit taken with hsync low", nlog, base);
    hsync = 1'b1;
    wait_n(3);
    send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    wait_n(6);
    check(nlog == base + 1, "R4 split byte written once", nlog, base + 1);
    check(log_d[base] == 8'hD6, "R4 partial byte kept across line", log_d[base], 8'hD6);
    check(log_a[base] == 2, "R5 address after split byte", log_a[base], 2);
  endtask

  task automatic t_fill();
    send_byte(8'h01);
    send_byte(8'h80);
    check(!ovf && done_cnt == 0, "R6 no done before last byte", done_cnt, 0);
    send_byte(8'hFF);
    check(nlog == 6, "R5 six bytes in frame", nlog, 6);
    check(log_a[5] == 5 && log_d[5] == 8'hFF, "R5 last byte at last address", log_a[5], 5);
    check(done_cnt == 1, "R6 one done pulse", done_cnt, 1);
    check(done_addr == 5 && done_wr == 1, "R6 done with final write", done_addr, 5);
    check(!ovf, "R7 no overflow at exact fill", ovf, 0);
    send_byte(8'h55);
    check(nlog == 6, "R7 extra byte dropped", nlog, 6);
    check(ovf, "R7 overflow raised", ovf, 1);
    wait_n(20);
    check(ovf, "R7 overflow sticky", ovf, 1);
  endtask

  task automatic t_restart();
    int base;
    send_bit(1); send_bit(1); send_bit(1);
    frame_start();
    check(!ovf, "R8 overflow cleared by vsync fall", ovf, 0);
    base = nlog;
    send_bit(1, 25);
    for (int i = 6; i >= 0; i--) send_bit(i == 0);
    wait_n(6);
    check(nlog == base + 1, "R2 long pclk high gives one bit", nlog, base + 1);
    check(log_d[base] == 8'h81, "R8 partial byte discarded, R2 single sample", log_d[base], 8'h81);
    check(log_a[base] == 0, "R8 address restarted", log_a[base], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_pack();
    t_line_split();
    t_fill();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule